// File: doc/BRIEF.md
# Configurable UART Transmit Channel

This block turns one byte from a client into an asynchronous serial frame on a single output line. A frame is a low start bit, the data bits in a selectable order, an optional parity bit, and zero, one or two high stop bits. Every bit lasts 2×(N+1) clock cycles, where N is a 7-bit divisor field. When the last bit of a frame has ended, a one-cycle transfer-end pulse tells the client that it can offer the next byte.

The byte enters through a valid/ready handshake. Ready is high only while the channel is enabled and no frame is in progress. A byte is taken in any cycle in which valid and ready are both high. Ready then stays low until the cycle after the final bit of that frame ends. A client that holds valid high while ready is low just waits; nothing is taken and nothing is lost. The framing fields and the byte are captured when the byte is accepted, so the client may change them while a frame is on the line.

The level the line rests at between frames comes from a programmable bit, which a system resets to 1. A separate output-enable bit decides whether the frame reaches the pin. While that bit is low, the pin is parked high.

Top module: `uart_tx_channel`

## Requirements
- R1: During and right after reset, tx_end is 0, tx_ready equals enable, and txd equals idle_lvl when out_en is 1.
- R2: A byte is accepted on a clock edge where tx_valid and tx_ready are both 1. From that edge until the final bit of the frame ends, tx_ready is 0.
- R3: After acceptance, txd sends a 0 start bit, then DATA_W data bits, then any parity bit, then any stop bits. Each bit lasts exactly 2×(cfg_div+1) clock cycles, and the start bit begins in the cycle after the accepting edge.
- R4: When cfg_msb_first is 0, the data bits are sent least significant bit first. When it is 1, they are sent most significant bit first.
- R5: cfg_parity selects the parity bit: 00 sends no parity bit, 01 sends a parity bit that is always 0, 10 sends even parity (the XOR of the data bits), and 11 sends odd parity (the inverse of that XOR).
- R6: cfg_stop selects the stop bits, each of level 1: 00 sends none, 01 sends one, and 10 or 11 sends two.
- R7: tx_end is 1 for exactly one cycle, in the cycle after the final bit ends. While enable is 1, tx_ready rises in that same cycle.
- R8: Whenever no frame is in progress and out_en is 1, txd equals idle_lvl.
- R9: While out_en is 0, txd is 1, including during a frame.
- R10: The byte and all cfg_* fields are captured at acceptance. Changing them, or holding tx_valid high, during a frame does not change that frame.
- R11: While enable is 0, tx_ready is 0 and tx_valid is ignored: no frame starts and tx_end stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new frames to be accepted |
| idle_lvl | input | 1 | Level of the line between frames |
| out_en | input | 1 | Passes the frame to txd; while it is 0, txd is parked high |
| cfg_div | input | DIV_W (7) | N: the bit period is 2×(N+1) clocks |
| cfg_parity | input | 2 | Parity code |
| cfg_stop | input | 2 | Stop-bit code |
| cfg_msb_first | input | 1 | 1 sends the MSB first |
| tx_data | input | DATA_W (8) | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | The channel can accept a byte |
| txd | output | 1 | Serial output |
| tx_end | output | 1 | One-cycle pulse after a frame ends |

## Verification
The hardest case to create from the ports is a frame that stays correct while its inputs are pulled away from it. Every configuration field and the byte change in the middle of the frame, and tx_valid is held high the whole time. The bench does this by changing all those inputs one cycle after acceptance and comparing txd in every cycle against the frame it captured. It lowers tx_valid just before the end, so no second frame starts by accident. Alongside the table of vectors, separate frames cover a zero-width divisor, frames with no stop bits, a low idle level, and a frame sent with out_en low.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_ZERO = 2'b01;
  localparam logic [1:0] PAR_EVEN = 2'b10;
  localparam logic [1:0] PAR_ODD  = 2'b11;

  // Number of stop bits for a stop code. Codes 10 and 11 both give two.
  function automatic logic [1:0] stop_count(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic parity_bit(input logic [1:0] code, input logic xr);
    case (code)
      PAR_EVEN: return xr;
      PAR_ODD:  return ~xr;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_baud.sv
// Bit-period timer: raises tick in the last cycle of each bit.
module uart_tx_baud #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  // The period is 2*(div+1) cycles, so the count runs from 0 to 2*div+1.
  assign limit = {div, 1'b1};
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (restart || tick || !run) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx_framer.sv
// Frame sequencer: captures the byte and configuration, then walks through the bit slots.
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              tick,
  input  logic [DATA_W-1:0] data_in,
  input  logic [DIV_W-1:0]  div_in,
  input  logic [1:0]        par_in,
  input  logic [1:0]        stop_in,
  input  logic              msb_in,
  input  logic              idle_lvl,
  output logic              busy,
  output logic [DIV_W-1:0]  div_q,
  output logic              line,
  output logic              end_pulse
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  tx_state_e         state_q;
  logic [DATA_W-1:0] data_q;
  logic [1:0]        par_q, stop_q, stop_cnt_q;
  logic              msb_q, end_q;
  logic [IDX_W-1:0]  idx_q, sel;
  logic              data_bit, pbit;

  assign sel      = msb_q ? (LAST_IDX - idx_q) : idx_q;
  assign data_bit = data_q[sel];
  assign pbit     = parity_bit(par_q, ^data_q);
  assign busy     = (state_q != ST_IDLE);
  assign end_pulse = end_q;

  always_comb begin
    case (state_q)
      ST_START: line = 1'b0;
      ST_DATA:  line = data_bit;
      ST_PAR:   line = pbit;
      ST_STOP:  line = 1'b1;
      default:  line = idle_lvl;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      data_q     <= '0;
      div_q      <= '0;
      par_q      <= PAR_NONE;
      stop_q     <= 2'b00;
      msb_q      <= 1'b0;
      idx_q      <= '0;
      stop_cnt_q <= 2'd0;
      end_q      <= 1'b0;
    end else begin
      end_q <= 1'b0;
      if (accept) begin
        state_q <= ST_START;
        data_q  <= data_in;
        div_q   <= div_in;
        par_q   <= par_in;
        stop_q  <= stop_in;
        msb_q   <= msb_in;
      end else if (tick) begin
        case (state_q)
          ST_START: begin
            state_q <= ST_DATA;
            idx_q   <= '0;
          end
          ST_DATA: begin
            if (idx_q != LAST_IDX) begin
              idx_q <= idx_q + 1'b1;
            end else if (par_q != PAR_NONE) begin
              state_q <= ST_PAR;
            end else if (stop_count(stop_q) != 2'd0) begin
              state_q    <= ST_STOP;
              stop_cnt_q <= 2'd0;
            end else begin
              state_q <= ST_IDLE;
              end_q   <= 1'b1;
            end
          end
          ST_PAR: begin
            if (stop_count(stop_q) != 2'd0) begin
              state_q    <= ST_STOP;
              stop_cnt_q <= 2'd0;
            end else begin
              state_q <= ST_IDLE;
              end_q   <= 1'b1;
            end
          end
          ST_STOP: begin
            if (stop_cnt_q == stop_count(stop_q) - 2'd1) begin
              state_q <= ST_IDLE;
              end_q   <= 1'b1;
            end else begin
              stop_cnt_q <= stop_cnt_q + 2'd1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_tx_channel.sv
module uart_tx_channel #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              idle_lvl,
  input  logic              out_en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [1:0]        cfg_parity,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_msb_first,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              txd,
  output logic              tx_end
);
  logic             busy, accept, tick, line;
  logic [DIV_W-1:0] div_q;

  assign tx_ready = enable && !busy;
  assign accept   = tx_valid && tx_ready;

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .run     (busy),
    .div     (div_q),
    .tick    (tick)
  );

  uart_tx_framer #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .tick      (tick),
    .data_in   (tx_data),
    .div_in    (cfg_div),
    .par_in    (cfg_parity),
    .stop_in   (cfg_stop),
    .msb_in    (cfg_msb_first),
    .idle_lvl  (idle_lvl),
    .busy      (busy),
    .div_q     (div_q),
    .line      (line),
    .end_pulse (tx_end)
  );

  // When the output is not enabled, the pin is parked high.
  assign txd = out_en ? line : 1'b1;
endmodule

// File: rtl/uart_tx_channel_sva.sv
module uart_tx_channel_sva (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic idle_lvl,
  input logic out_en,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic tx_end
);
  p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  p_end_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |=> !tx_end);

  p_end_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && enable) |-> tx_ready);

  p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && out_en) |-> (txd == idle_lvl));

  p_parked_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en) |-> txd);

  p_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |-> !tx_ready);
endmodule

bind uart_tx_channel uart_tx_channel_sva u_sva (
  .clk(clk), .rst_n(rst_n), .enable(enable), .idle_lvl(idle_lvl),
  .out_en(out_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .txd(txd), .tx_end(tx_end)
);

// File: tb/uart_tx_channel_test.sv
module uart_tx_channel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1, idle_lvl = 1'b1, out_en = 1'b1;
  logic [6:0] cfg_div = '0;
  logic [1:0] cfg_parity = '0, cfg_stop = 2'b01;
  logic       cfg_msb_first = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready, txd, tx_end;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_tx_channel uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .idle_lvl(idle_lvl),
    .out_en(out_en), .cfg_div(cfg_div), .cfg_parity(cfg_parity),
    .cfg_stop(cfg_stop), .cfg_msb_first(cfg_msb_first), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .tx_end(tx_end)
  );

  // Vector layout: {msb_first, stop[1:0], parity[1:0], div[1:0], data[7:0]}
  localparam logic [14:0] VEC [9] = '{
    {1'b0, 2'b01, 2'b00, 2'd0, 8'h54},
    {1'b0, 2'b01, 2'b10, 2'd1, 8'h74},
    {1'b1, 2'b01, 2'b11, 2'd1, 8'hA5},
    {1'b0, 2'b10, 2'b01, 2'd2, 8'h3C},
    {1'b1, 2'b00, 2'b10, 2'd0, 8'h81},
    {1'b0, 2'b11, 2'b11, 2'd3, 8'hFF},
    {1'b1, 2'b10, 2'b00, 2'd0, 8'h00},
    {1'b0, 2'b00, 2'b00, 2'd1, 8'h0D},
    {1'b0, 2'b01, 2'b10, 2'd0, 8'h4F}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Sends one frame and checks txd, tx_ready and tx_end in every cycle.
  // scramble=1 changes every input during the frame and holds tx_valid high (R10).
  task automatic send(input logic [7:0] d, input logic [6:0] dv, input logic [1:0] par,
                      input logic [1:0] stp, input logic msb, input bit scramble,
                      input string req);
    logic ebits [16];
    int   n = 0;
    int   per = 2 * (int'(dv) + 1);
    int   nst;
    logic expd;
    ebits[n++] = 1'b0;
    for (int i = 0; i < 8; i++) ebits[n++] = msb ? d[7-i] : d[i];
    if (par == 2'b01) ebits[n++] = 1'b0;
    if (par == 2'b10) ebits[n++] = ^d;
    if (par == 2'b11) ebits[n++] = ~^d;
    nst = (stp == 2'b00) ? 0 : (stp == 2'b01) ? 1 : 2;
    for (int i = 0; i < nst; i++) ebits[n++] = 1'b1;

    @(negedge clk);
    tx_data = d; cfg_div = dv; cfg_parity = par; cfg_stop = stp;
    cfg_msb_first = msb; tx_valid = 1'b1;
    chk(tx_ready == 1'b1, {req, " R2 ready before accept"}, tx_ready, 1);
    @(posedge clk);
    for (int k = 1; k <= n * per; k++) begin
      @(negedge clk);
      if (!scramble && k == 1) tx_valid = 1'b0;
      if (scramble && k == 1) begin
        tx_data = ~d; cfg_div = dv + 7'd1; cfg_parity = ~par;
        cfg_stop = ~stp; cfg_msb_first = ~msb;
      end
      if (k == n * per) tx_valid = 1'b0;
      expd = out_en ? ebits[(k - 1) / per] : 1'b1;
      chk(txd == expd, {req, " R3 txd bit"}, txd, expd);
      chk(tx_ready == 1'b0, {req, " R2 ready low in frame"}, tx_ready, 0);
      chk(tx_end == 1'b0, {req, " R7 no early end"}, tx_end, 0);
    end
    @(negedge clk);
    chk(tx_end == 1'b1, {req, " R7 end pulse"}, tx_end, 1);
    chk(tx_ready == enable, {req, " R7 ready with end"}, tx_ready, enable);
    chk(txd == (out_en ? idle_lvl : 1'b1), {req, " R8 idle after frame"}, txd, idle_lvl);
    @(negedge clk);
    chk(tx_end == 1'b0, {req, " R7 end one cycle"}, tx_end, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(tx_end == 1'b0, "R1 end in reset", tx_end, 0);
    chk(tx_ready == 1'b1, "R1 ready in reset", tx_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1, "R1 idle high", txd, 1);
    chk(tx_ready == 1'b1, "R1 ready after reset", tx_ready, 1);

    // Table of vectors: R3, R4, R5, R6
    for (int v = 0; v < 9; v++) begin
      send(VEC[v][7:0], {5'd0, VEC[v][9:8]}, VEC[v][11:10], VEC[v][13:12],
           VEC[v][14], 1'b0, $sformatf("R4 R5 R6 vec%0d", v));
    end

    // R10: inputs changed mid-frame and valid held high
    send(8'hC6, 7'd2, 2'b10, 2'b01, 1'b0, 1'b1, "R10 scramble");
    @(negedge clk);
    chk(tx_ready == 1'b1, "R10 no second frame", tx_ready, 1);
    chk(txd == 1'b1, "R10 line idle", txd, 1);

    // R8: low idle level
    idle_lvl = 1'b0;
    @(negedge clk);
    chk(txd == 1'b0, "R8 idle low", txd, 0);
    send(8'h5A, 7'd1, 2'b11, 2'b01, 1'b1, 1'b0, "R8 frame idle low");

    // R9: output disabled, the pin stays high through a frame
    out_en = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R9 parked idle", txd, 1);
    send(8'h00, 7'd0, 2'b01, 2'b10, 1'b0, 1'b0, "R9 frame parked");
    out_en = 1'b1;
    idle_lvl = 1'b1;

    // R11: disabled channel ignores valid
    @(negedge clk);
    enable = 1'b0;
    tx_valid = 1'b1;
    tx_data = 8'h00;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(tx_ready == 1'b0, "R11 ready low", tx_ready, 0);
      chk(txd == 1'b1, "R11 no frame", txd, 1);
      chk(tx_end == 1'b0, "R11 no end", tx_end, 0);
    end
    tx_valid = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R11 ready back", tx_ready, 1);

    // Longest divisor in the bench, with two stop bits
    send(8'h96, 7'd5, 2'b10, 2'b10, 1'b1, 1'b0, "R3 R6 wide div");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule